// File: doc/BRIEF.md
# Address-Triggered Load/Store Register File

This block holds the architectural registers of a datapath in which memory traffic is a side effect of writing an address register. There are three banks of eight registers each. The address bank and the index bank are 18 bits wide, and the data bank is 60 bits wide. Writing an address register with index 1 to 5 queues a read of that address, and the returned word lands in the data register with the same index. Writing address register 6 or 7 queues a write of the same-index data register to that address. The data is sampled in the cycle the address is written. Address register 0 is plain storage, and index register 0 is a constant zero.

The queued requests leave in program order through a memory port with a valid/ready handshake. Only one request is in flight at a time. A read holds the port until its response arrives, and a write completes at its handshake. Each data register that is waiting on a read shows a busy flag. A stall output warns the datapath that the request queue is full. If the datapath writes a data register directly while a read to it is pending, the late result is dropped.

Top module: `addr_trig_regfile`

## Requirements
- R1: After reset every register reads zero, all busy flags are low, `stall` is low and `mem_req_valid` is low.
- R2: A write with `wr_bank` 0 (address), 1 (index) or 2 (data) updates the register at `wr_idx`, and the read port returns it in the next cycle using the same bank encoding. Address and index registers keep `wr_data[17:0]` and read back zero-extended to 60 bits.
- R3: Index register 0 always reads zero, and writes to it are ignored.
- R4: A write to address register 0 stores the value and queues no memory request.
- R5: A write to address register n, with n from 1 to 5, queues a read (`mem_req_write`=0) at the written address. The response data is in data register n in the cycle after `mem_rsp_valid`.
- R6: A write to address register 6 or 7 queues a write (`mem_req_write`=1) carrying the value that data register 6 or 7 held when the address was written. Later writes to that data register do not change the queued word.
- R7: `x_busy[n]` rises in the cycle after a read is triggered for data register n. It falls in the cycle after the last pending read's response arrives. `rd_busy` is high when the read port selects a busy data register.
- R8: Requests leave in the order their address writes occurred. No new request is offered while a read response is outstanding.
- R9: `stall` is high exactly when QDEPTH requests are queued and not yet issued. While it is high, writes to address registers 1 to 7 are ignored: the register is unchanged and no request is queued.
- R10: A direct write to a data register discards every read result still pending for it and clears its busy flag.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 2 | Bank of write: 0 address, 1 index, 2 data |
| wr_idx | input | 3 | Register index of write |
| wr_data | input | 60 | Write value |
| rd_bank | input | 2 | Bank of read |
| rd_idx | input | 3 | Register index of read |
| rd_data | output | 60 | Read value (zero-extended for 18-bit banks) |
| rd_busy | output | 1 | Selected data register awaits a read |
| x_busy | output | 8 | Per data register pending-read flags |
| stall | output | 1 | Request queue full |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 18 | Word address |
| mem_req_wdata | output | 60 | Write word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 60 | Read data |

## Verification
The bench builds the block with QDEPTH set to 4. At that depth, a few address writes made while the memory holds `mem_req_ready` low are enough to fill the queue. This exercises the ignored-write path under stall and queue wrap-around. The small depth also lets repeated reads to one data register stack up, so several results can be discarded after a direct write.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
    localparam int AW        = 18;
    localparam int DW        = 60;
    localparam int NREG      = 8;
    localparam int IW        = $clog2(NREG);
    localparam int LOAD_LAST = 5;

    typedef enum logic [1:0] {
        BANK_A = 2'd0,
        BANK_B = 2'd1,
        BANK_X = 2'd2,
        BANK_N = 2'd3
    } bank_e;

    typedef struct packed {
        logic          wr;
        logic [IW-1:0] idx;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } mreq_t;
endpackage

// File: rtl/mrf_req_fifo.sv
module mrf_req_fifo
    import mrf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  mreq_t push_entry,
    input  logic  pop,
    output mreq_t head,
    output logic  empty,
    output logic  full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        mreq_t [DEPTH-1:0] slot;
        logic  [PW-1:0]    wp;
        logic  [PW-1:0]    rp;
        logic  [CW-1:0]    cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    assign head  = st_q.slot[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.slot[st_q.wp] = push_entry;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_no_push_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/mrf_mem_seq.sv
module mrf_mem_seq
    import mrf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_empty,
    input  mreq_t         q_head,
    output logic          q_pop,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    output logic          rsp_fire,
    output logic [IW-1:0] rsp_idx
);
    typedef struct packed {
        logic          waiting;
        logic [IW-1:0] idx;
    } seq_st_t;

    seq_st_t st_d, st_q;

    assign mem_req_valid = !st_q.waiting && !q_empty;
    assign mem_req_write = q_head.wr;
    assign mem_req_addr  = q_head.addr;
    assign mem_req_wdata = q_head.data;
    assign q_pop         = mem_req_valid && mem_req_ready;
    assign rsp_fire      = st_q.waiting && mem_rsp_valid;
    assign rsp_idx       = st_q.idx;

    always_comb begin
        st_d = st_q;
        if (q_pop && !q_head.wr) begin
            st_d.waiting = 1'b1;
            st_d.idx     = q_head.idx;
        end else if (rsp_fire) begin
            st_d.waiting = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid
            && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));
    p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && !mem_req_write) |=> !mem_req_valid);
endmodule

// File: rtl/mrf_regbank.sv
module mrf_regbank
    import mrf_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_bank,
    input  logic [IW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic [1:0]      rd_bank,
    input  logic [IW-1:0]   rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic            rd_busy,
    output logic [NREG-1:0] x_busy,
    input  logic            stall,
    input  logic            rsp_fire,
    input  logic [IW-1:0]   rsp_idx,
    input  logic [DW-1:0]   rsp_data,
    output logic            push,
    output mreq_t           push_entry
);
    localparam int CW = $clog2(QDEPTH + 2);

    typedef struct packed {
        logic [NREG-1:0][AW-1:0] a;
        logic [NREG-1:0][AW-1:0] b;
        logic [NREG-1:0][DW-1:0] x;
        logic [NREG-1:0][CW-1:0] pend;
        logic [NREG-1:0][CW-1:0] kill;
    } rb_st_t;

    rb_st_t st_d, st_q;
    logic   a_wr, trig, is_load;

    assign a_wr    = wr_en && (wr_bank == BANK_A);
    assign trig    = a_wr && (wr_idx != '0) && !stall;
    assign is_load = (32'(wr_idx) <= LOAD_LAST);

    assign push            = trig;
    assign push_entry.wr   = !is_load;
    assign push_entry.idx  = wr_idx;
    assign push_entry.addr = wr_data[AW-1:0];
    assign push_entry.data = st_q.x[wr_idx];

    always_comb begin
        st_d = st_q;
        if (a_wr && ((wr_idx == '0) || !stall)) st_d.a[wr_idx] = wr_data[AW-1:0];
        if (wr_en && (wr_bank == BANK_B) && (wr_idx != '0)) st_d.b[wr_idx] = wr_data[AW-1:0];
        for (int i = 0; i < NREG; i++) begin
            logic rsp_i, dir_i, ld_i;
            logic [CW-1:0] pend_left;
            rsp_i = rsp_fire && (rsp_idx == IW'(i));
            dir_i = wr_en && (wr_bank == BANK_X) && (wr_idx == IW'(i));
            ld_i  = trig && is_load && (wr_idx == IW'(i));
            pend_left = st_q.pend[i] - CW'(rsp_i);
            st_d.pend[i] = pend_left + CW'(ld_i);
            if (dir_i) begin
                st_d.x[i]    = wr_data;
                st_d.kill[i] = pend_left;
            end else if (rsp_i) begin
                if (st_q.kill[i] != '0) st_d.kill[i] = st_q.kill[i] - 1'b1;
                else                    st_d.x[i]    = rsp_data;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NREG; i++) x_busy[i] = (st_q.pend[i] > st_q.kill[i]);
        case (rd_bank)
            BANK_A:  rd_data = DW'(st_q.a[rd_idx]);
            BANK_B:  rd_data = DW'(st_q.b[rd_idx]);
            BANK_X:  rd_data = st_q.x[rd_idx];
            default: rd_data = '0;
        endcase
        rd_busy = (rd_bank == BANK_X) && x_busy[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_b0_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.b[0] == '0);
    p_busy_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && is_load) |=> x_busy[$past(wr_idx)]);
    p_direct_clears_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bank == BANK_X) |=> !x_busy[$past(wr_idx)]);
endmodule

// File: rtl/addr_trig_regfile.sv
module addr_trig_regfile
    import mrf_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_bank,
    input  logic [2:0]  wr_idx,
    input  logic [59:0] wr_data,
    input  logic [1:0]  rd_bank,
    input  logic [2:0]  rd_idx,
    output logic [59:0] rd_data,
    output logic        rd_busy,
    output logic [7:0]  x_busy,
    output logic        stall,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic        mem_req_write,
    output logic [17:0] mem_req_addr,
    output logic [59:0] mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [59:0] mem_rsp_rdata
);
    logic          push, pop, q_empty, q_full, rsp_fire;
    logic [IW-1:0] rsp_idx;
    mreq_t         push_entry, q_head;

    assign stall = q_full;

    mrf_regbank #(.QDEPTH(QDEPTH)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data), .rd_busy(rd_busy),
        .x_busy(x_busy), .stall(q_full),
        .rsp_fire(rsp_fire), .rsp_idx(rsp_idx), .rsp_data(mem_rsp_rdata),
        .push(push), .push_entry(push_entry)
    );

    mrf_req_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_entry(push_entry), .pop(pop),
        .head(q_head), .empty(q_empty), .full(q_full)
    );

    mrf_mem_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .q_empty(q_empty), .q_head(q_head), .q_pop(pop),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .rsp_fire(rsp_fire), .rsp_idx(rsp_idx)
    );
endmodule

// File: tb/addr_trig_regfile_tb_top.sv
module addr_trig_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [1:0]  wr_bank = '0, rd_bank = '0;
    logic [2:0]  wr_idx = '0, rd_idx = '0;
    logic [59:0] wr_data = '0, mem_rsp_rdata = '0, mem_req_wdata, rd_data;
    logic        rd_busy, stall, mem_req_valid, mem_req_write;
    logic [7:0]  x_busy;
    logic [17:0] mem_req_addr;

    addr_trig_regfile #(.QDEPTH(QD)) dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [17:0] m_a [8], m_b [8];
    logic [59:0] m_x [8];
    int          m_pend [8], m_kill [8];
    logic        q_wr [64];
    logic [2:0]  q_idx [64];
    logic [17:0] q_addr [64];
    logic [59:0] q_data [64];
    int          q_h = 0, q_t = 0;
    bit          m_wait = 0;
    logic [2:0]  w_idx;
    logic [17:0] w_addr;
    bit          hold_prev = 0;
    logic [17:0] hold_addr;
    logic [59:0] hold_data;
    logic        hold_wr;

    function automatic logic [59:0] data_of(logic [17:0] a);
        return {a, a ^ 18'h2AAAA, 24'hC0FFEE ^ {6'd0, a}};
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [59:0] exp_rd(logic [1:0] bk, logic [2:0] ix);
        case (bk)
            2'd0: return {42'd0, m_a[ix]};
            2'd1: return {42'd0, m_b[ix]};
            2'd2: return m_x[ix];
            default: return '0;
        endcase
    endfunction

    function automatic logic [7:0] exp_busy();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = (m_pend[i] > m_kill[i]);
        return v;
    endfunction

    // one clock: check outputs, drive inputs, advance the model
    task automatic step(bit we, logic [1:0] bk, logic [2:0] ix, logic [59:0] d,
                        bit rdy, bit rsp, logic [1:0] rbk, logic [2:0] rix);
        bit exp_valid, exp_stall, hs;
        @(negedge clk);
        rd_bank = rbk; rd_idx = rix;
        #1;
        exp_stall = ((q_t - q_h) == QD);
        exp_valid = !m_wait && (q_t != q_h);
        chk(rd_data == exp_rd(rbk, rix), "R2 read port", 64'(rd_data), 64'(exp_rd(rbk, rix)));
        chk(x_busy == exp_busy(), "R7 busy flags", 64'(x_busy), 64'(exp_busy()));
        chk(rd_busy == (rbk == 2'd2 && exp_busy()[rix]), "R7 rd_busy", 64'(rd_busy), 64'(rbk == 2'd2 && exp_busy()[rix]));
        chk(stall == exp_stall, "R9 stall", 64'(stall), 64'(exp_stall));
        chk(mem_req_valid == exp_valid, "R8 req valid", 64'(mem_req_valid), 64'(exp_valid));
        if (hold_prev)
            chk(mem_req_valid && mem_req_addr == hold_addr && mem_req_wdata == hold_data
                && mem_req_write == hold_wr, "R11 hold", 64'(mem_req_addr), 64'(hold_addr));
        if (exp_valid) begin
            chk(mem_req_write == q_wr[q_h % 64] && mem_req_addr == q_addr[q_h % 64],
                "R5 req kind/addr", {45'd0, mem_req_write, mem_req_addr},
                {45'd0, q_wr[q_h % 64], q_addr[q_h % 64]});
            if (q_wr[q_h % 64])
                chk(mem_req_wdata == q_data[q_h % 64], "R6 store data",
                    64'(mem_req_wdata), 64'(q_data[q_h % 64]));
        end
        rsp = rsp && m_wait;
        wr_en = we; wr_bank = bk; wr_idx = ix; wr_data = d;
        mem_req_ready = rdy; mem_rsp_valid = rsp;
        mem_rsp_rdata = rsp ? data_of(w_addr) : {$urandom, $urandom};
        hs = exp_valid && rdy;
        hold_prev = exp_valid && !rdy;
        hold_addr = mem_req_addr; hold_data = mem_req_wdata; hold_wr = mem_req_write;
        if (hs) begin
            if (!q_wr[q_h % 64]) begin
                m_wait = 1; w_idx = q_idx[q_h % 64]; w_addr = q_addr[q_h % 64];
            end
            q_h++;
        end else if (rsp) begin
            m_wait = 0;
            m_pend[w_idx]--;
            if (m_kill[w_idx] > 0) m_kill[w_idx]--;
            else m_x[w_idx] = data_of(w_addr);
        end
        if (we) begin
            if (bk == 2'd0) begin
                if (ix == 0) m_a[0] = d[17:0];
                else if (!exp_stall) begin
                    m_a[ix] = d[17:0];
                    q_wr[q_t % 64] = (ix >= 6); q_idx[q_t % 64] = ix;
                    q_addr[q_t % 64] = d[17:0]; q_data[q_t % 64] = m_x[ix];
                    q_t++;
                    if (ix < 6) m_pend[ix]++;
                end
            end else if (bk == 2'd1) begin
                if (ix != 0) m_b[ix] = d[17:0];
            end else if (bk == 2'd2) begin
                m_x[ix] = d;
                m_kill[ix] = m_pend[ix];
            end
        end
        @(posedge clk);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 2'd2, 3'(k));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=running exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 8; i++) begin
            m_a[i] = '0; m_b[i] = '0; m_x[i] = '0; m_pend[i] = 0; m_kill[i] = 0;
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk(x_busy == 0 && !stall && !mem_req_valid, "R1 reset outputs",
            {61'd0, |x_busy, stall, mem_req_valid}, 64'd0);
        for (int b = 0; b < 3; b++)
            for (int i = 0; i < 8; i++) begin
                rd_bank = 2'(b); rd_idx = 3'(i); #1;
                chk(rd_data == 0, "R1 reset regs", 64'(rd_data), 64'd0);
            end
        // R3: index 0 stays zero
        step(1, 2'd1, 3'd0, 60'h3FFFF, 0, 0, 2'd1, 3'd0);
        step(0, 0, 0, 0, 0, 0, 2'd1, 3'd0);
        chk(rd_data == 0, "R3 index zero", 64'(rd_data), 64'd0);
        // R4: address 0 has no side effect
        step(1, 2'd0, 3'd0, 60'h12345, 1, 0, 2'd0, 3'd0);
        step(0, 0, 0, 0, 1, 0, 2'd0, 3'd0);
        chk(!mem_req_valid && rd_data == 60'h12345, "R4 a0 quiet", {3'd0, mem_req_valid, rd_data}, 64'h12345);
        // R6: store captures X6 at address write time
        step(1, 2'd2, 3'd6, 60'hABCDEF, 0, 0, 2'd2, 3'd6);
        step(1, 2'd0, 3'd6, 60'h00100, 0, 0, 2'd2, 3'd6);
        step(1, 2'd2, 3'd6, 60'h777, 0, 0, 2'd2, 3'd6);
        chk(mem_req_write && mem_req_wdata == 60'hABCDEF, "R6 captured word", 64'(mem_req_wdata), 64'hABCDEF);
        step(0, 0, 0, 0, 1, 0, 2'd2, 3'd6);
        // R10: direct write drops late load data
        step(1, 2'd0, 3'd2, 60'h00222, 1, 0, 2'd2, 3'd2);
        step(0, 0, 0, 0, 1, 0, 2'd2, 3'd2);
        chk(x_busy[2], "R7 busy set", 64'(x_busy), 64'h4);
        step(1, 2'd2, 3'd2, 60'h5A5A5, 0, 0, 2'd2, 3'd2);
        step(0, 0, 0, 0, 0, 1, 2'd2, 3'd2);
        step(0, 0, 0, 0, 0, 0, 2'd2, 3'd2);
        chk(rd_data == 60'h5A5A5 && !x_busy[2], "R10 discard", 64'(rd_data), 64'h5A5A5);
        // R9: fill the queue with ready low, then an ignored write
        for (int i = 1; i <= 5; i++) step(1, 2'd0, 3'(i), 60'(18'h1000 + i), 0, 0, 2'd0, 3'(i));
        step(0, 0, 0, 0, 0, 0, 2'd0, 3'd5);
        chk(stall && rd_data == 0, "R9 full ignores", {3'd0, stall, rd_data}, 64'h1000000000000000);
        // R5: drain with responses
        for (int k = 0; k < 30; k++) step(0, 0, 0, 0, 1, 1, 2'd2, 3'(k % 5 + 1));
        chk(!stall && x_busy == 0, "R5 drained", {55'd0, stall, x_busy}, 64'd0);
        // constrained random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [1:0] bk;
            bk = ($urandom % 4 < 2) ? 2'd0 : 2'($urandom % 3);
            step($urandom % 2, bk, 3'($urandom % 8), {$urandom, $urandom} & 60'hFFFFFFFFFFFFFFF,
                 $urandom % 2, ($urandom % 5) < 2, 2'($urandom % 4), 3'($urandom % 8));
        end
        idle(40);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule